// File: doc/BRIEF.md
# At-Speed Scan Test Sequencer

This block drives two-vector delay tests through one muxed-data scan chain. It accepts a pattern on a valid/ready port. A pattern is made of the first vector, a set of primary-input values and a single launch bit. The block shifts the vector in at a slow cadence and then issues the launch and capture events. The gated clock pulses and the scan-enable are timed for the selected test style.

Two styles are supported, and `mode_i` chooses between them:
- **Skewed-load (launch-on-shift).** One extra shift forms the second vector. The capture pulse comes on the very next fast cycle, with scan-enable already low.
- **Broadside (launch-on-capture).** Scan-enable drops after the scan-in. Two back-to-back system pulses then launch and capture. An optional idle slow period before the launch gives a slow scan-enable time to settle.

Captured responses leave the chain while the next pattern is shifted in. Each complete response is presented on a one-cycle valid port.

A small scan chain with a fixed functional logic cloud is built in, so that the whole flow can be exercised. Each cell is a 2:1 mux, selected by scan-enable, in front of a flop. Both the shift and the system pulses clock the flop. The functional value of cell i is `q[(i+1) mod N] ^ pi[i mod PI_W] ^ (i odd)`. Scan-in enters cell 0, and scan-out is cell N-1.

Top module: `scan_seq_top`

## Requirements
- R1: Scan-in presents the first vector most-significant bit first, one bit per shift pulse, so that after N shifts cell i holds `vec_data_i[i]`.
- R2: In skewed-load mode (`mode_i`=1) exactly N+1 shift pulses are issued per pattern. The last shift carries `los_bit_i`, so that cell 0 receives the launch bit and cell i receives `vec_data_i[i-1]`.
- R3: In skewed-load mode exactly one system pulse is issued per pattern, one clock cycle after the launch shift pulse. Scan-enable is low during that pulse.
- R4: In broadside mode (`mode_i`=0) exactly N shift pulses are issued per pattern. They are followed by two system pulses on consecutive clock cycles, with scan-enable low during both.
- R5: Consecutive shift pulses within a pattern are RATIO cycles apart. In broadside mode without the dummy period, the launch pulse comes RATIO cycles after the last shift pulse.
- R6: In broadside mode with `dummy_en_i`=1, the launch pulse comes 2*RATIO cycles after the last shift pulse. In skewed-load mode `dummy_en_i` has no effect on timing.
- R7: `pi_o` takes the pattern's primary-input value at acceptance and holds it until the next pattern is accepted.
- R8: The captured chain contents of a pattern are shifted out during the next pattern's scan-in. They then appear on `resp_data_o` (bit i = captured cell i) for exactly one cycle with `resp_valid_o`.
- R9: The scan-out during the first pattern after reset is discarded, with no `resp_valid_o`. Each later pattern yields exactly one response for its predecessor.
- R10: While reset is held and right after it is released, scan-enable is high, both clock pulses are off, `resp_valid_o` is low and `vec_ready_o` is high.
- R11: `vec_ready_o` is low from the cycle after acceptance until the capture of that pattern has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 1 = skewed-load, 0 = broadside (sampled at acceptance) |
| dummy_en_i | input | 1 | Insert idle slow period before broadside launch |
| vec_valid_i | input | 1 | Pattern offered |
| vec_ready_o | output | 1 | Pattern can be accepted |
| vec_data_i | input | N | First vector, bit i for cell i |
| pi_data_i | input | PI_W | Primary-input values for the pattern |
| los_bit_i | input | 1 | Bit shifted in by the skewed-load launch shift |
| scan_en_o | output | 1 | Scan-enable to the chain muxes |
| shift_clk_o | output | 1 | Slow shift clock pulse (gating enable) |
| sys_clk_o | output | 1 | Fast system clock pulse (gating enable) |
| scan_in_o | output | 1 | Serial scan-in data |
| scan_out_o | output | 1 | Serial scan-out from the last cell |
| pi_o | output | PI_W | Held primary-input values |
| resp_valid_o | output | 1 | One-cycle response strobe |
| resp_data_o | output | N | Unloaded response, bit i = cell i |

## Verification
The bench sweeps every combination of mode and dummy setting over a run of arithmetic patterns. For each pattern it computes the second vector and the capture in software, then ends with a flush pattern.

It targets the following corner cases:
- **Skewed-load launch shift.** A design that forgot the extra shift would capture from the first vector, and the responses would mismatch. A design that lowered scan-enable one cycle late would see the capture pulse with scan-enable high.
- **Broadside timing.** The bench measures the gap from the last shift to the launch pulse. A missing or doubled dummy period shifts this gap by RATIO. A slow launch-to-capture interval shows up as a gap larger than one cycle.
- **First-pattern discard and bit order.** A response strobe after the first pattern, or a reversed bit order, is reported against the expected value.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_LAUNCH_SHIFT,
    ST_DUMMY,
    ST_LAUNCH,
    ST_CAPTURE,
    ST_UNLOAD
  } seq_state_e;
endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int N     = 8,
  parameter int PI_W  = 2,
  parameter int RATIO = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_i,
  input  logic            dummy_en_i,
  input  logic            vec_valid_i,
  output logic            vec_ready_o,
  input  logic [N-1:0]    vec_data_i,
  input  logic [PI_W-1:0] pi_data_i,
  input  logic            los_bit_i,
  output logic            scan_en_o,
  output logic            shift_pulse_o,
  output logic            sys_pulse_o,
  output logic            scan_in_o,
  output logic [PI_W-1:0] pi_o,
  output logic            unload_done_o
);
  localparam int DW = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam int CW = $clog2(N + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(RATIO - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(N - 1);

  seq_state_e      state_q, state_d;
  logic [DW-1:0]   div_q;
  logic [CW-1:0]   cnt_q;
  logic [N-1:0]    ld_q;
  logic [PI_W-1:0] pi_q;
  logic            lb_q, los_q, dmy_q, pend_q;
  logic            tick, timed, accept;

  assign timed  = (state_q == ST_SHIFT) || (state_q == ST_LAUNCH_SHIFT) ||
                  (state_q == ST_DUMMY) || (state_q == ST_LAUNCH);
  assign tick   = timed && (div_q == DIV_LAST);
  assign vec_ready_o = (state_q == ST_IDLE) || (state_q == ST_UNLOAD);
  assign accept = vec_valid_i && vec_ready_o;

  assign scan_en_o     = (state_q == ST_IDLE) || (state_q == ST_SHIFT) ||
                         (state_q == ST_LAUNCH_SHIFT) || (state_q == ST_UNLOAD);
  assign shift_pulse_o = tick && ((state_q == ST_SHIFT) || (state_q == ST_LAUNCH_SHIFT));
  assign sys_pulse_o   = (tick && (state_q == ST_LAUNCH)) || (state_q == ST_CAPTURE);
  assign scan_in_o     = (state_q == ST_LAUNCH_SHIFT) ? lb_q : ld_q[N-1];
  assign pi_o          = pi_q;
  assign unload_done_o = (state_q == ST_SHIFT) && tick && (cnt_q == CNT_LAST) && pend_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_UNLOAD: if (accept) state_d = ST_SHIFT;
      ST_SHIFT: if (tick && cnt_q == CNT_LAST)
                  state_d = los_q ? ST_LAUNCH_SHIFT : (dmy_q ? ST_DUMMY : ST_LAUNCH);
      ST_LAUNCH_SHIFT: if (tick) state_d = ST_CAPTURE;
      ST_DUMMY:        if (tick) state_d = ST_LAUNCH;
      ST_LAUNCH:       if (tick) state_d = ST_CAPTURE;
      ST_CAPTURE:      state_d = ST_UNLOAD;
      default:         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      div_q   <= '0;
      cnt_q   <= '0;
      ld_q    <= '0;
      pi_q    <= '0;
      lb_q    <= 1'b0;
      los_q   <= 1'b0;
      dmy_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      div_q   <= (timed && !tick) ? div_q + DW'(1) : '0;
      if (accept) begin
        ld_q  <= vec_data_i;
        pi_q  <= pi_data_i;
        lb_q  <= los_bit_i;
        los_q <= mode_i;
        dmy_q <= dummy_en_i;
        cnt_q <= '0;
      end else if (shift_pulse_o && state_q == ST_SHIFT) begin
        ld_q  <= {ld_q[N-2:0], 1'b0};
        cnt_q <= cnt_q + CW'(1);
      end
      if (state_q == ST_CAPTURE) pend_q <= 1'b1;
      else if (unload_done_o)    pend_q <= 1'b0;
    end
  end

  assert_sys_se_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_pulse_o |-> !scan_en_o);
  assert_pulse_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_pulse_o && sys_pulse_o));
  assert_los_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_pulse_o && state_q == ST_LAUNCH_SHIFT) |=> (sys_pulse_o && !scan_en_o));
  assert_loc_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_pulse_o && state_q == ST_LAUNCH) |=> sys_pulse_o);
  assert_pi_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(pi_o));
  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(N));
endmodule

// File: rtl/scan_chain_model.sv
module scan_chain_model #(
  parameter int N    = 8,
  parameter int PI_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clk_en_i,
  input  logic            se_i,
  input  logic            si_i,
  input  logic [PI_W-1:0] pi_i,
  output logic            so_o
);
  logic [N-1:0] q, func;

  for (genvar g = 0; g < N; g++) begin : g_cell
    localparam int NX = (g + 1) % N;
    logic ser;
    if (g == 0) begin : g_head
      assign ser = si_i;
    end else begin : g_body
      assign ser = q[g-1];
    end
    assign func[g] = q[NX] ^ pi_i[g % PI_W] ^ 1'(g % 2);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q[g] <= 1'b0;
      else if (clk_en_i) q[g] <= se_i ? ser : func[g];
    end
  end

  assign so_o = q[N-1];
endmodule

// File: rtl/scan_resp_unload.sv
module scan_resp_unload #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         so_i,
  input  logic         done_i,
  output logic         resp_valid_o,
  output logic [N-1:0] resp_data_o
);
  logic [N-1:0] sr_q;
  logic         vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      if (shift_i) sr_q <= {sr_q[N-2:0], so_i};
      vld_q <= done_i;
    end
  end

  assign resp_valid_o = vld_q;
  assign resp_data_o  = sr_q;

  assert_single_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);
  assert_done_on_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> shift_i);
endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
  parameter int N     = 8,
  parameter int PI_W  = 2,
  parameter int RATIO = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mode_i,
  input  logic            dummy_en_i,
  input  logic            vec_valid_i,
  output logic            vec_ready_o,
  input  logic [N-1:0]    vec_data_i,
  input  logic [PI_W-1:0] pi_data_i,
  input  logic            los_bit_i,
  output logic            scan_en_o,
  output logic            shift_clk_o,
  output logic            sys_clk_o,
  output logic            scan_in_o,
  output logic            scan_out_o,
  output logic [PI_W-1:0] pi_o,
  output logic            resp_valid_o,
  output logic [N-1:0]    resp_data_o
);
  logic done;

  scan_seq_ctrl #(.N(N), .PI_W(PI_W), .RATIO(RATIO)) u_ctrl (
    .clk_i, .rst_ni, .mode_i, .dummy_en_i, .vec_valid_i, .vec_ready_o,
    .vec_data_i, .pi_data_i, .los_bit_i, .scan_en_o,
    .shift_pulse_o(shift_clk_o), .sys_pulse_o(sys_clk_o),
    .scan_in_o, .pi_o, .unload_done_o(done)
  );

  scan_chain_model #(.N(N), .PI_W(PI_W)) u_chain (
    .clk_i, .rst_ni, .clk_en_i(shift_clk_o | sys_clk_o), .se_i(scan_en_o),
    .si_i(scan_in_o), .pi_i(pi_o), .so_o(scan_out_o)
  );

  scan_resp_unload #(.N(N)) u_unload (
    .clk_i, .rst_ni, .shift_i(shift_clk_o), .so_i(scan_out_o), .done_i(done),
    .resp_valid_o, .resp_data_o
  );
endmodule

// File: tb/scan_seq_top_tb.sv
module scan_seq_top_tb;
  localparam int N = 8, PW = 2, R = 4, NPAT = 32;

  logic clk = 0, rst_n = 0;
  logic mode = 0, dmy = 0, valid = 0, lb = 0;
  logic [N-1:0] vec = '0;
  logic [PW-1:0] pi = '0;
  logic ready, se, shc, syc, si, so, rvld;
  logic [PW-1:0] pio;
  logic [N-1:0] rdat;

  scan_seq_top #(.N(N), .PI_W(PW), .RATIO(R)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .dummy_en_i(dmy),
    .vec_valid_i(valid), .vec_ready_o(ready), .vec_data_i(vec), .pi_data_i(pi),
    .los_bit_i(lb), .scan_en_o(se), .shift_clk_o(shc), .sys_clk_o(syc),
    .scan_in_o(si), .scan_out_o(so), .pi_o(pio), .resp_valid_o(rvld), .resp_data_o(rdat)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, nshift = 0, nsys = 0, t_last = 0, t_sys1 = 0, t_sys2 = 0, nresp = 0;
  logic [N-1:0] pend_exp;
  logic pend_ok = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] fmod(input logic [N-1:0] q, input logic [PW-1:0] p);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = q[(i + 1) % N] ^ p[i % PW] ^ 1'(i % 2);
    return r;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (valid && ready) begin
      nshift = 0; nsys = 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (shc) begin
      if (nshift > 0) chk(cyc - t_last == R, "R5 shift spacing", cyc - t_last, R);
      if (nshift < N) chk(si == vec[N-1-nshift], "R1 scan-in bit", si, vec[N-1-nshift]);
      else chk(si == lb, "R2 launch-shift bit", si, lb);
      t_last = cyc; nshift++;
    end
    if (syc) begin
      chk(!se, "R3/R4 scan-enable low at system pulse", se, 0);
      chk(pio == pi, "R7 pi held", pio, pi);
      if (nsys == 0) t_sys1 = cyc; else t_sys2 = cyc;
      nsys++;
    end
    if (rvld) begin
      nresp++;
      chk(pend_ok, "R9 response only after a captured pattern", 1, pend_ok);
      chk(rdat == pend_exp, "R8 response data", rdat, pend_exp);
      pend_ok = 0;
    end
  end

  task automatic run_pat(input logic m, input logic d, input logic [N-1:0] v,
                         input logic [PW-1:0] p, input logic b);
    logic [N-1:0] v2, cap;
    int lsh;
    @(negedge clk);
    while (!ready) @(negedge clk);
    mode = m; dmy = d; vec = v; pi = p; lb = b; valid = 1;
    @(negedge clk);
    valid = 0;
    chk(!ready, "R11 ready low after accept", ready, 0);
    while (!ready) @(negedge clk);
    if (m) begin
      v2 = {v[N-2:0], b};
      chk(nshift == N + 1, "R2 shift count", nshift, N + 1);
      chk(nsys == 1, "R3 single system pulse", nsys, 1);
      chk(t_sys1 - t_last == 1, "R3/R6 capture one cycle after launch shift", t_sys1 - t_last, 1);
    end else begin
      v2 = fmod(v, p);
      lsh = d ? 2 * R : R;
      chk(nshift == N, "R4 shift count", nshift, N);
      chk(nsys == 2, "R4 two system pulses", nsys, 2);
      chk(t_sys2 - t_sys1 == 1, "R4 launch-capture spacing", t_sys2 - t_sys1, 1);
      chk(t_sys1 - t_last == lsh, d ? "R6 dummy launch gap" : "R5 launch gap", t_sys1 - t_last, lsh);
    end
    cap = fmod(v2, p);
    pend_exp = cap; pend_ok = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(se && !shc && !syc && !rvld && ready, "R10 state in reset", {se, shc, syc, rvld, ready}, 5'b10001);
    rst_n = 1;
    @(negedge clk);
    chk(se && !shc && !syc && !rvld && ready, "R10 state after reset", {se, shc, syc, rvld, ready}, 5'b10001);
    for (int k = 0; k < NPAT; k++)
      run_pat(k[0], k[1], N'((k * 37 + 5) ^ (k << 3)), PW'(k >> 2), k[2] ^ k[3]);
    chk(nresp == NPAT - 1, "R9 response count before flush", nresp, NPAT - 1);
    run_pat(1'b0, 1'b0, '0, '0, 1'b0);
    repeat (2) @(negedge clk);
    chk(nresp == NPAT, "R9 response count", nresp, NPAT);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule